// File: doc/BRIEF.md
# Trailing-Edge Slave FIFO Write Port

This block is the receive side of a slave FIFO that an external controller fills without sharing a clock. The controller presents a byte, pulses a write strobe, and the byte is taken when the strobe returns to its inactive level. The write pointer then moves on by one. A separate packet-end strobe commits every byte written since the previous commit as one packet, even a short one. All strobes, the chip select, the data bus and the address lines are brought into the local clock domain through two-flop synchronizers. Edges are then found in that domain.

Bytes stay hidden from the read side until they are committed. Committed bytes are offered in write order on a show-ahead pop interface, and the final byte of each packet is marked. A registered full flag counts both committed and pending bytes. A one-cycle committed pulse marks each packet end. A sticky overflow bit records writes that were dropped because the FIFO was full. A sticky protocol-error bit records two kinds of misuse: a write and a packet-end seen active together, or the address lines moving while packet-end is active. The active level of the write, packet-end and chip-select pins is set by configuration inputs.

Top module: `sfifo_wr_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `full`, `rd_valid`, `pkt_done`, `overflow` and `proto_err` are all 0.
- R2: The stored byte is the value on `ext_data` when the write strobe goes back to its inactive level. A value that was present only while the strobe was asserted is never stored.
- R3: Written bytes are not readable (`rd_valid` = 0) until a packet-end commits them. Committed bytes come out in write order, `rd_data` shows the oldest byte, and `rd_pop` with `rd_valid` high removes it.
- R4: `pkt_done` is high for exactly the one cycle that follows the third rising clock edge after the packet-end pin becomes active.
- R5: `full` becomes 1 at the third rising edge after the deasserting pin change of the write that brings the stored count (pending plus committed) to DEPTH. It is still 0 after the second edge. It returns to 0 at the clock edge that accepts a pop.
- R6: A write that completes while the FIFO holds DEPTH bytes is dropped. The stored contents stay the same, and `overflow` becomes 1 and stays 1 until reset.
- R7: A write or packet-end counts only if chip select is active when the strobe's assertion is detected. When `cfg_cs_tied` is 1, chip select is ignored.
- R8: Each of `cfg_wr_high`, `cfg_pe_high` and `cfg_cs_high` selects its pin's active level: 1 means active-high and 0 means active-low. The behaviour is the same under either setting.
- R9: If the write and packet-end strobes are seen active together, `proto_err` is set and stays set until reset.
- R10: If `ext_addr` changes while packet-end is active, `proto_err` is set. When the address holds steady during packet-end, the bit is not set.
- R11: A packet-end with no pending bytes still pulses `pkt_done`, and it makes nothing readable.
- R12: The `rd_last` output is 1 exactly when `rd_data` is the final byte of a committed packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_high | input | 1 | Write strobe active level (1 = high) |
| cfg_pe_high | input | 1 | Packet-end strobe active level (1 = high) |
| cfg_cs_high | input | 1 | Chip select active level (1 = high) |
| cfg_cs_tied | input | 1 | Treat chip select as always active |
| ext_cs | input | 1 | Asynchronous chip select |
| ext_wr | input | 1 | Asynchronous write strobe |
| ext_pe | input | 1 | Asynchronous packet-end strobe |
| ext_addr | input | AW | FIFO address, must hold steady during packet-end |
| ext_data | input | DW | Write data bus |
| rd_pop | input | 1 | Remove the byte shown on rd_data |
| rd_valid | output | 1 | A committed byte is available |
| rd_data | output | DW | Oldest committed byte |
| rd_last | output | 1 | rd_data ends its packet |
| full | output | 1 | DEPTH bytes stored |
| pkt_done | output | 1 | One-cycle pulse per accepted packet-end |
| overflow | output | 1 | Sticky: a write was dropped while full |
| proto_err | output | 1 | Sticky: strobe overlap or address change during packet-end |

## Verification
A pin change takes effect at the third rising edge after it: two synchronizer flops, then the register that acts on the detected edge. So `full`, `pkt_done`, `overflow` and `proto_err` are compared one, two and three falling edges after the pin change, which confirms the flag is absent before that third edge and present after it. A pop is registered at the rising edge it straddles, so `full` and the read outputs are checked at the next falling edge. All inputs change on falling edges and all outputs are sampled on falling edges, never at an active edge.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  // Level and edge view of one synchronized strobe, already in active polarity.
  typedef struct packed {
    logic act;
    logic rise;
    logic fall;
  } strobe_t;

endpackage

// File: rtl/sfw_sync.sv
module sfw_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/sfw_edge.sv
module sfw_edge
  import sfw_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    lvl,
  output strobe_t st
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  always_comb begin
    st.act  = lvl;
    st.rise = lvl & ~prev_q;
    st.fall = ~lvl & prev_q;
  end

endmodule

// File: rtl/sfw_ram.sv
module sfw_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Single synchronous write port, asynchronous read (distributed RAM).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sfifo_wr_port.sv
module sfifo_wr_port
  import sfw_pkg::*;
#(
  parameter int DEPTH = 16,   // power of two
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr_high,
  input  logic          cfg_pe_high,
  input  logic          cfg_cs_high,
  input  logic          cfg_cs_tied,
  input  logic          ext_cs,
  input  logic          ext_wr,
  input  logic          ext_pe,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_data,
  input  logic          rd_pop,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          full,
  output logic          pkt_done,
  output logic          overflow,
  output logic          proto_err
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  // Polarity is folded in ahead of the synchronizer so reset value 0 means inactive.
  logic [2:0] ctl_act, ctl_s;
  assign ctl_act = {ext_cs ~^ cfg_cs_high, ext_pe ~^ cfg_pe_high, ext_wr ~^ cfg_wr_high};

  sfw_sync #(.W(3)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_act), .q(ctl_s)
  );

  logic [AW+DW-1:0] bus_s;
  sfw_sync #(.W(AW + DW)) u_bus_sync (
    .clk(clk), .rst(rst), .d({ext_addr, ext_data}), .q(bus_s)
  );

  logic [DW-1:0] data_s;
  logic [AW-1:0] addr_s, addr_q;
  assign data_s = bus_s[DW-1:0];
  assign addr_s = bus_s[AW+DW-1:DW];

  strobe_t wr_st, pe_st;
  sfw_edge u_wr_edge (.clk(clk), .rst(rst), .lvl(ctl_s[0]), .st(wr_st));
  sfw_edge u_pe_edge (.clk(clk), .rst(rst), .lvl(ctl_s[1]), .st(pe_st));

  logic cs_ok;
  assign cs_ok = ctl_s[2] | cfg_cs_tied;

  logic [CW-1:0] wptr, rptr, cptr;
  logic [CW-1:0] wptr_n, rptr_n, used;
  logic [DEPTH-1:0] last_q;
  logic wr_armed, wr_go, wr_do, pe_go, pop_do, full_now, has_pending;

  assign used        = wptr - rptr;
  assign full_now    = (used == DEPTH_C);
  assign has_pending = (wptr != cptr);
  assign wr_go       = wr_st.fall & wr_armed;
  assign wr_do       = wr_go & ~full_now;
  assign pe_go       = pe_st.rise & cs_ok;
  assign rd_valid    = (rptr != cptr);
  assign pop_do      = rd_pop & rd_valid;
  assign wptr_n      = wptr + CW'(wr_do);
  assign rptr_n      = rptr + CW'(pop_do);

  sfw_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_do), .waddr(wptr[PW-1:0]), .wdata(data_s),
    .raddr(rptr[PW-1:0]), .rdata(rd_data)
  );

  assign rd_last = last_q[rptr[PW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cptr      <= '0;
      wr_armed  <= 1'b0;
      addr_q    <= '0;
      full      <= 1'b0;
      pkt_done  <= 1'b0;
      overflow  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      addr_q   <= addr_s;
      wptr     <= wptr_n;
      rptr     <= rptr_n;
      if (wr_st.rise) wr_armed <= cs_ok;
      if (pe_go)      cptr     <= wptr_n;
      full     <= ((wptr_n - rptr_n) == DEPTH_C);
      pkt_done <= pe_go;
      if (wr_go && full_now) overflow <= 1'b1;
      if ((wr_st.act && pe_st.act) || (pe_st.act && (addr_s != addr_q)))
        proto_err <= 1'b1;
    end
  end

  // Packet boundary bits: one write per cycle; a same-cycle write closes the packet itself.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
    end else if (wr_do) begin
      last_q[wptr[PW-1:0]] <= pe_go;
    end else if (pe_go && has_pending) begin
      last_q[wptr[PW-1:0] - PW'(1)] <= 1'b1;
    end
  end

  AST_RST_CLEAN: assert property (@(posedge clk)
    rst |=> (!full && !rd_valid && !pkt_done && !overflow && !proto_err)); // R1
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_pop) |=> rd_valid); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (wptr - rptr) <= DEPTH_C); // R5
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_do) |=> $stable(wptr)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err); // R9

endmodule

// File: tb/tb_sfifo_wr_port.sv
`timescale 1ns/1ps
module tb_sfifo_wr_port;

  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr_high = 1'b0, cfg_pe_high = 1'b0, cfg_cs_high = 1'b0, cfg_cs_tied = 1'b0;
  logic ext_cs = 1'b1, ext_wr = 1'b1, ext_pe = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [DW-1:0] ext_data = '0;
  logic rd_pop = 1'b0;
  logic rd_valid, rd_last, full, pkt_done, overflow, proto_err;
  logic [DW-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;   // 250 MHz

  sfifo_wr_port #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst),
    .cfg_wr_high(cfg_wr_high), .cfg_pe_high(cfg_pe_high),
    .cfg_cs_high(cfg_cs_high), .cfg_cs_tied(cfg_cs_tied),
    .ext_cs(ext_cs), .ext_wr(ext_wr), .ext_pe(ext_pe),
    .ext_addr(ext_addr), .ext_data(ext_data), .rd_pop(rd_pop),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .full(full), .pkt_done(pkt_done), .overflow(overflow), .proto_err(proto_err)
  );

  // {cs active, commit after this byte, data}
  localparam logic [9:0] VEC [8] = '{
    {1'b1, 1'b0, 8'hA1}, {1'b1, 1'b0, 8'hB2}, {1'b0, 1'b0, 8'hC3}, {1'b1, 1'b0, 8'hD4},
    {1'b1, 1'b1, 8'hE5}, {1'b1, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h77}, {1'b1, 1'b1, 8'hFF}
  };

  logic [7:0] exp_d [32];
  logic       exp_l [32];
  int n_exp = 0;
  int pend  = 0;

  function automatic logic pin(input logic act, input logic high);
    return high ? act : ~act;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_pins();
    ext_cs = pin(1'b0, cfg_cs_high);
    ext_wr = pin(1'b0, cfg_wr_high);
    ext_pe = pin(1'b0, cfg_pe_high);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    idle_pins();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Bus shows ~d while strobe is first asserted, d only before release (R2).
  task automatic do_write(input logic [7:0] d, input logic cs_on, input logic chk_full);
    @(negedge clk);
    ext_cs   = pin(cs_on, cfg_cs_high);
    ext_data = ~d;
    ext_wr   = pin(1'b1, cfg_wr_high);
    repeat (3) @(negedge clk);
    ext_data = d;
    repeat (3) @(negedge clk);
    ext_wr = pin(1'b0, cfg_wr_high);
    repeat (2) @(negedge clk);
    if (chk_full) check("R5 full before third edge", full, 0);
    @(negedge clk);
    if (chk_full) check("R5 full at third edge", full, 1);
    repeat (2) @(negedge clk);
    ext_cs = pin(1'b0, cfg_cs_high);
  endtask

  task automatic pulse_pe();
    @(negedge clk);
    ext_cs = pin(1'b1, cfg_cs_high);
    ext_pe = pin(1'b1, cfg_pe_high);
    repeat (2) @(negedge clk);
    check("R4 pkt_done early", pkt_done, 0);
    @(negedge clk);
    check("R4 pkt_done due", pkt_done, 1);
    @(negedge clk);
    check("R4 pkt_done width", pkt_done, 0);
    ext_pe = pin(1'b0, cfg_pe_high);
    repeat (4) @(negedge clk);
    ext_cs = pin(1'b0, cfg_cs_high);
  endtask

  task automatic pop_expect(input logic [7:0] d, input logic last, input string tag);
    @(negedge clk);
    check({tag, " valid"}, rd_valid, 1);
    check({tag, " data"}, rd_data, d);
    check({tag, " R12 last"}, rd_last, last);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_pins();
    repeat (2) @(negedge clk);
    check("R1 full in reset", full, 0);
    check("R1 valid in reset", rd_valid, 0);
    reset_dut();
    @(negedge clk);
    check("R1 pkt_done", pkt_done, 0);
    check("R1 overflow", overflow, 0);
    check("R1 proto_err", proto_err, 0);

    // Table walk: cs-gated writes (R7), commits (R3), short packets
    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][7:0], VEC[i][9], 1'b0);
      if (VEC[i][9]) begin
        exp_d[n_exp] = VEC[i][7:0];
        exp_l[n_exp] = 1'b0;
        n_exp++;
        pend++;
      end
      if (i == 0) check("R3 hidden before commit", rd_valid, 0);
      if (VEC[i][8]) begin
        pulse_pe();
        if (pend > 0) exp_l[n_exp-1] = 1'b1;
        pend = 0;
      end
    end
    for (int i = 0; i < n_exp; i++) pop_expect(exp_d[i], exp_l[i], "R2 R3 R7 table");
    @(negedge clk);
    check("R3 drained", rd_valid, 0);

    // Zero-length commit
    pulse_pe();
    check("R11 empty commit", rd_valid, 0);

    // Fill to DEPTH, then overflow
    for (int i = 0; i < DEPTH - 1; i++) do_write(8'h10 + 8'(i), 1'b1, 1'b0);
    do_write(8'h10 + 8'(DEPTH - 1), 1'b1, 1'b1);
    check("R6 no overflow yet", overflow, 0);
    do_write(8'hEE, 1'b1, 1'b0);
    check("R6 overflow set", overflow, 1);
    pulse_pe();
    pop_expect(8'h10, 1'b0, "R6 first");
    check("R5 full clears on pop", full, 0);
    for (int i = 1; i < DEPTH; i++)
      pop_expect(8'h10 + 8'(i), (i == DEPTH - 1), "R6 contents kept");
    @(negedge clk);
    check("R6 dropped byte absent", rd_valid, 0);
    check("R6 overflow sticky", overflow, 1);

    // Chip select tied active
    cfg_cs_tied = 1'b1;
    do_write(8'h5A, 1'b0, 1'b0);
    pulse_pe();
    pop_expect(8'h5A, 1'b1, "R7 tied cs");
    cfg_cs_tied = 1'b0;

    // Active-high polarity
    @(negedge clk);
    cfg_wr_high = 1'b1; cfg_pe_high = 1'b1; cfg_cs_high = 1'b1;
    reset_dut();
    do_write(8'h3C, 1'b1, 1'b0);
    do_write(8'hC3, 1'b1, 1'b0);
    pulse_pe();
    pop_expect(8'h3C, 1'b0, "R8 high pol");
    pop_expect(8'hC3, 1'b1, "R8 high pol");
    check("R10 steady addr no error", proto_err, 0);

    // Overlapping strobes
    @(negedge clk);
    ext_cs = pin(1'b1, cfg_cs_high);
    ext_wr = pin(1'b1, cfg_wr_high);
    ext_pe = pin(1'b1, cfg_pe_high);
    repeat (5) @(negedge clk);
    idle_pins();
    repeat (5) @(negedge clk);
    check("R9 overlap error", proto_err, 1);
    repeat (3) @(negedge clk);
    check("R9 error sticky", proto_err, 1);

    // Address change during packet-end
    reset_dut();
    @(negedge clk);
    check("R1 error cleared", proto_err, 0);
    ext_cs = pin(1'b1, cfg_cs_high);
    ext_pe = pin(1'b1, cfg_pe_high);
    repeat (4) @(negedge clk);
    check("R10 no error while steady", proto_err, 0);
    ext_addr = 2'd3;
    repeat (4) @(negedge clk);
    idle_pins();
    repeat (3) @(negedge clk);
    check("R10 address change error", proto_err, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule